// File: doc/BRIEF.md
# Sample-Qualified Threshold Fault Detector

This block watches a set of measurement streams and raises a fault flag when the selected stream crosses an 11-bit limit often enough. Every stream has two data words, an absolute reading and an error reading, and a strobe that marks when a new sample is present. A select field chooses one stream and one of its two words. A comparison is made only when the selected stream's strobe is high. A polarity bit sets whether a reading above the threshold or a reading below it counts as a fault.

Faulting samples drive a small counter upward. When the counter reaches the programmed limit, it locks and the fault flag stays high until software pulses the clear input. A mode bit sets what a clean sample does to a counter that has not locked. In one mode it wipes the counter. In the other mode it steps the counter down by one, stopping at zero. With the second mode, a fault that appears on more than half of the samples eventually trips the flag. The counter value is always visible on an output. A separate enable gates the interrupt.

Top module: `thresh_fault_qual`

## Requirements
- R1: After synchronous reset, `fault_cnt` is 0 and both `fault` and `irq` are low.
- R2: With `cfg_below`=0, a sample strictly greater than `cfg_thresh` is a fault sample. A sample equal to the threshold is never a fault. Samples are unsigned.
- R3: With `cfg_below`=1, a sample strictly less than `cfg_thresh` is a fault sample.
- R4: `cfg_src[0]` selects the data word: 0 takes the absolute word and 1 takes the error word. `cfg_src[SEL_W-1:1]` gives the channel index, and channel i occupies bits [i*11 +: 11] of both data buses. Strobes of channels that are not selected have no effect.
- R5: With `cfg_decay`=0, a clean sample on an unlocked counter sets it to 0 on the next cycle.
- R6: With `cfg_decay`=1, a clean sample on an unlocked counter decrements it by one, and leaves it at 0 if it is already 0.
- R7: A fault sample on an unlocked counter increments it on the next cycle. When the new value is at least `cfg_limit`, the counter locks. While locked, the count holds and further samples are ignored.
- R8: `clr`=1 sets the count to 0 and unlocks on the next edge. This takes priority over a sample in the same cycle.
- R9: With `cfg_en`=0, samples are ignored (the count holds) and `fault` is low. The lock state is kept.
- R10: `fault` equals (locked AND `cfg_en`), and `irq` equals `fault` AND `cfg_irq_en`.
- R11: A channel index that is not below NUM_SRC never produces a comparison.
- R12: A `cfg_limit` of 0 behaves like 1: the first fault sample locks with a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_abs | input | NUM_SRC*SMP_W | Absolute data words, channel i at [i*SMP_W +: SMP_W] |
| smp_err | input | NUM_SRC*SMP_W | Error data words, same packing |
| smp_vld | input | NUM_SRC | New-sample strobe per channel |
| cfg_en | input | 1 | Block enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_below | input | 1 | 1: below threshold is a fault; 0: above |
| cfg_decay | input | 1 | 1: clean sample decrements; 0: clean sample clears |
| cfg_src | input | SEL_W | Bit 0 word choice, upper bits channel index |
| cfg_thresh | input | SMP_W | Threshold |
| cfg_limit | input | CNT_W | Count at which the counter locks |
| clr | input | 1 | Clear count and lock |
| fault | output | 1 | Qualified fault flag |
| irq | output | 1 | Interrupt |
| fault_cnt | output | CNT_W | Current count |

## Verification
The bench aims at samples that sit exactly on the threshold. A design with a non-strict compare would count these and trip early. It also checks decay mode at a count of zero, where an unguarded decrement would wrap to the maximum and lock at once. Clear is raised in the same cycle as a fault sample, to catch a design that lets the increment win. Strobes are pulsed on unselected channels and on the index beyond the last channel, so a mux that ignores the index or the word bit shows up as a wrong count. Samples arriving while the counter is locked or disabled would move the count or drop the flag if the lock or the enable were not honoured.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    localparam int unsigned DEF_NUM_SRC = 3;
    localparam int unsigned DEF_SMP_W   = 11;
    localparam int unsigned DEF_CNT_W   = 4;

    // outcome of one comparison
    typedef struct packed {
        logic seen;   // a selected sample arrived
        logic hit;    // that sample is a fault sample
    } verdict_t;

    // what the counter does this cycle
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_INC  = 3'd1,
        ACT_WIPE = 3'd2,
        ACT_DEC  = 3'd3
    } cnt_act_e;

    function automatic cnt_act_e choose_action(
        input logic     en,
        input verdict_t v,
        input logic     locked,
        input logic     decay,
        input logic     at_zero
    );
        cnt_act_e a;
        if (!en || !v.seen || locked) a = ACT_HOLD;
        else if (v.hit)               a = ACT_INC;
        else if (!decay)              a = ACT_WIPE;
        else if (at_zero)             a = ACT_HOLD;
        else                          a = ACT_DEC;
        return a;
    endfunction

endpackage

// File: rtl/dcmp_src_mux.sv
module dcmp_src_mux #(
    parameter int unsigned NUM_SRC = dcmp_pkg::DEF_NUM_SRC,
    parameter int unsigned SMP_W   = dcmp_pkg::DEF_SMP_W,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC*SMP_W-1:0] abs_bus,
    input  logic [NUM_SRC*SMP_W-1:0] err_bus,
    input  logic [NUM_SRC-1:0]       vld_bus,
    input  logic [IDX_W-1:0]         chan_idx,
    input  logic                     use_err,
    output logic [SMP_W-1:0]         sel_data,
    output logic                     sel_valid
);

    logic [NUM_SRC-1:0] chan_match;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chan
        assign chan_match[g] = (chan_idx == IDX_W'(g));
    end

    always_comb begin
        sel_data  = '0;
        sel_valid = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (chan_match[i]) begin
                sel_data  = use_err ? err_bus[i*SMP_W +: SMP_W]
                                    : abs_bus[i*SMP_W +: SMP_W];
                sel_valid = vld_bus[i];
            end
        end
    end

    // R11: an index past the last channel never yields a sample
    p_ghost_chan_r11: assert property (@(posedge clk) disable iff (rst)
        (int'(chan_idx) >= int'(NUM_SRC)) |-> !sel_valid);

endmodule

// File: rtl/dcmp_judge.sv
module dcmp_judge #(
    parameter int unsigned SMP_W = dcmp_pkg::DEF_SMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  sample,
    input  logic              sample_vld,
    input  logic [SMP_W-1:0]  thresh,
    input  logic              below,
    output dcmp_pkg::verdict_t verdict
);

    logic over, under;

    always_comb begin
        over         = sample > thresh;
        under        = sample < thresh;
        verdict.seen = sample_vld;
        verdict.hit  = sample_vld && (below ? under : over);
    end

    // R2: a sample on the threshold is never a fault
    p_equal_clean_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sample == thresh) |-> !verdict.hit);

    // R3: in below mode a fault sample lies under the threshold
    p_below_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (verdict.hit && below) |-> (sample < thresh));

endmodule

// File: rtl/dcmp_counter.sv
module dcmp_counter #(
    parameter int unsigned CNT_W = dcmp_pkg::DEF_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               en,
    input  logic               decay,
    input  logic [CNT_W-1:0]   limit,
    input  dcmp_pkg::verdict_t verdict,
    output logic [CNT_W-1:0]   count,
    output logic               locked
);
    import dcmp_pkg::*;

    cnt_act_e         act;
    logic [CNT_W-1:0] cnt_nxt;
    logic             lock_nxt;

    always_comb begin
        act      = choose_action(en, verdict, locked, decay, count == '0);
        cnt_nxt  = count;
        lock_nxt = locked;
        unique case (act)
            ACT_INC: begin
                cnt_nxt  = count + 1'b1;
                lock_nxt = (cnt_nxt >= limit);
            end
            ACT_WIPE: cnt_nxt = '0;
            ACT_DEC:  cnt_nxt = count - 1'b1;
            default:  cnt_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count  <= '0;
            locked <= 1'b0;
        end else begin
            count  <= cnt_nxt;
            locked <= lock_nxt;
        end
    end

    // R8: clear wins over anything else
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !locked));

    // R7: a locked counter holds until cleared
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && !clr) |=> (locked && $stable(count)));

    // R7: a fault sample steps the count up
    p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && verdict.hit && !locked) |=> (count == $past(count) + 1'b1));

    // R5: clear-on-clean mode
    p_wipe_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && verdict.seen && !verdict.hit && !locked && !decay) |=> (count == '0));

    // R6: decay mode never wraps below zero
    p_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && verdict.seen && !verdict.hit && !locked && decay && count == '0)
        |=> (count == '0));

    // R9: disabled counter keeps its value
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> ($stable(count) && $stable(locked)));

endmodule

// File: rtl/thresh_fault_qual.sv
module thresh_fault_qual #(
    parameter int unsigned NUM_SRC = dcmp_pkg::DEF_NUM_SRC,
    parameter int unsigned SMP_W   = dcmp_pkg::DEF_SMP_W,
    parameter int unsigned CNT_W   = dcmp_pkg::DEF_CNT_W,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned SEL_W  = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC*SMP_W-1:0] smp_abs,
    input  logic [NUM_SRC*SMP_W-1:0] smp_err,
    input  logic [NUM_SRC-1:0]       smp_vld,
    input  logic                     cfg_en,
    input  logic                     cfg_irq_en,
    input  logic                     cfg_below,
    input  logic                     cfg_decay,
    input  logic [SEL_W-1:0]         cfg_src,
    input  logic [SMP_W-1:0]         cfg_thresh,
    input  logic [CNT_W-1:0]         cfg_limit,
    input  logic                     clr,
    output logic                     fault,
    output logic                     irq,
    output logic [CNT_W-1:0]         fault_cnt
);
    import dcmp_pkg::*;

    logic [SMP_W-1:0] sel_data;
    logic             sel_valid;
    verdict_t         verdict;
    logic             locked;

    dcmp_src_mux #(.NUM_SRC(NUM_SRC), .SMP_W(SMP_W), .IDX_W(IDX_W)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .abs_bus  (smp_abs),
        .err_bus  (smp_err),
        .vld_bus  (smp_vld),
        .chan_idx (cfg_src[SEL_W-1:1]),
        .use_err  (cfg_src[0]),
        .sel_data (sel_data),
        .sel_valid(sel_valid)
    );

    dcmp_judge #(.SMP_W(SMP_W)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .sample    (sel_data),
        .sample_vld(sel_valid),
        .thresh    (cfg_thresh),
        .below     (cfg_below),
        .verdict   (verdict)
    );

    dcmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .en     (cfg_en),
        .decay  (cfg_decay),
        .limit  (cfg_limit),
        .verdict(verdict),
        .count  (fault_cnt),
        .locked (locked)
    );

    always_comb begin
        fault = locked && cfg_en;
        irq   = fault && cfg_irq_en;
    end

    // R10: no interrupt without its enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |-> !irq);

    // R1: reset leaves the detector idle
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (fault_cnt == '0 && !fault));

endmodule

// File: tb/thresh_fault_qual_test.sv
module thresh_fault_qual_test;
    localparam int NS = 3;
    localparam int DW = 11;
    localparam int CW = 4;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic [NS*DW-1:0] smp_abs = '0;
    logic [NS*DW-1:0] smp_err = '0;
    logic [NS-1:0]    smp_vld = '0;
    logic             cfg_en = 1'b1, cfg_irq_en = 1'b1, cfg_below = 1'b0, cfg_decay = 1'b0;
    logic [SW-1:0]    cfg_src = '0;
    logic [DW-1:0]    cfg_thresh = 11'd500;
    logic [CW-1:0]    cfg_limit = 4'd3;
    logic             clr = 1'b0;
    logic             fault, irq;
    logic [CW-1:0]    fault_cnt;

    thresh_fault_qual uut (
        .clk(clk), .rst(rst), .smp_abs(smp_abs), .smp_err(smp_err), .smp_vld(smp_vld),
        .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en), .cfg_below(cfg_below), .cfg_decay(cfg_decay),
        .cfg_src(cfg_src), .cfg_thresh(cfg_thresh), .cfg_limit(cfg_limit), .clr(clr),
        .fault(fault), .irq(irq), .fault_cnt(fault_cnt)
    );

    int    tests = 0;
    int    fails = 0;
    string tag = "R1";
    int    m_cnt = 0;
    bit    m_lk = 1'b0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        summary();
    end

    // one clock: model follows the inputs seen at the edge, outputs checked at the falling edge
    task automatic cyc();
        int idx;
        bit valid;
        int d;
        bit hit, exp_f, exp_i;
        @(posedge clk);
        idx   = int'(cfg_src >> 1);
        valid = 1'b0;
        d     = 0;
        if (idx < NS) begin
            valid = smp_vld[idx];
            d = cfg_src[0] ? int'(smp_err[idx*DW +: DW]) : int'(smp_abs[idx*DW +: DW]);
        end
        if (rst || clr) begin
            m_cnt = 0;
            m_lk  = 1'b0;
        end else if (cfg_en && valid && !m_lk) begin
            hit = cfg_below ? (d < int'(cfg_thresh)) : (d > int'(cfg_thresh));
            if (hit) begin
                m_cnt++;
                if (m_cnt >= int'(cfg_limit)) m_lk = 1'b1;
            end else if (!cfg_decay) m_cnt = 0;
            else if (m_cnt > 0) m_cnt--;
        end
        @(negedge clk);
        exp_f = m_lk && cfg_en;
        exp_i = exp_f && cfg_irq_en;
        tests++;
        if (fault_cnt !== CW'(m_cnt) || fault !== exp_f || irq !== exp_i) begin
            fails++;
            $display("FAIL %s: cnt=%0d fault=%0b irq=%0b, expected cnt=%0d fault=%0b irq=%0b",
                     tag, fault_cnt, fault, irq, m_cnt, exp_f, exp_i);
        end
    endtask

    task automatic set_word(int ch, bit err, int val);
        if (err) smp_err[ch*DW +: DW] = DW'(val);
        else     smp_abs[ch*DW +: DW] = DW'(val);
    endtask

    // present one sample on the selected stream; the other word carries a decoy value
    task automatic feed(int ch, bit err, int val);
        cfg_src = {2'(ch), err};
        set_word(ch, err, val);
        set_word(ch, !err, val ^ 11'h7FF);
        smp_vld = '0;
        smp_vld[ch] = 1'b1;
        cyc();
        smp_vld = '0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        cyc();
        clr = 1'b0;
    endtask

    initial begin
        tag = "R1";
        cyc();
        cyc();
        rst = 1'b0;
        cyc();

        tag = "R2";
        cfg_thresh = 11'd500; cfg_limit = 4'd5;
        feed(0, 0, 500); feed(0, 0, 501); feed(0, 0, 2047); feed(0, 0, 500);
        feed(0, 0, 600); feed(0, 0, 499);
        do_clear();

        tag = "R3";
        cfg_below = 1'b1;
        feed(1, 0, 499); feed(1, 0, 500); feed(1, 0, 0); feed(1, 0, 0);
        do_clear();
        cfg_below = 1'b0;

        tag = "R4";
        feed(1, 1, 900); feed(1, 1, 900); feed(1, 0, 900);
        do_clear();
        cfg_src = {2'd1, 1'b1};
        set_word(0, 0, 2000); set_word(0, 1, 2000); set_word(2, 0, 2000); set_word(2, 1, 2000);
        set_word(1, 1, 10);
        smp_vld = 3'b101; cyc(); smp_vld = 3'b101; cyc(); smp_vld = '0; cyc();
        feed(2, 1, 700); feed(2, 0, 100);

        tag = "R5";
        do_clear();
        cfg_decay = 1'b0;
        feed(0, 0, 800); feed(0, 0, 800); feed(0, 0, 100); feed(0, 0, 800);

        tag = "R6";
        do_clear();
        cfg_decay = 1'b1;
        feed(0, 0, 100); feed(0, 0, 100); feed(0, 0, 800); feed(0, 0, 800);
        feed(0, 0, 100); feed(0, 0, 100); feed(0, 0, 100);
        for (int k = 0; k < 8; k++) feed(0, 0, (k % 3 == 2) ? 100 : 800);

        tag = "R7";
        do_clear();
        cfg_limit = 4'd3;
        feed(0, 0, 800); feed(0, 0, 800); feed(0, 0, 800); feed(0, 0, 100);
        feed(0, 0, 800); cyc();

        tag = "R8";
        clr = 1'b1; feed(0, 0, 800); clr = 1'b0;
        feed(0, 0, 800); cyc();
        cfg_limit = 4'd15;
        for (int k = 0; k < 16; k++) feed(0, 0, 1500);
        do_clear();

        tag = "R9";
        cfg_limit = 4'd2;
        feed(0, 0, 800); cfg_en = 1'b0;
        feed(0, 0, 800); feed(0, 0, 800); feed(0, 0, 100);
        cfg_en = 1'b1; feed(0, 0, 800); cfg_en = 1'b0; cyc(); cyc();
        cfg_en = 1'b1; cyc();

        tag = "R10";
        cfg_irq_en = 1'b0; cyc(); cfg_irq_en = 1'b1; cyc();
        do_clear();

        tag = "R11";
        cfg_src = 3'b110; smp_vld = '1; set_word(0, 0, 2047); cyc(); cyc();
        cfg_src = 3'b111; cyc(); smp_vld = '0; cyc();

        tag = "R12";
        cfg_limit = 4'd0; cfg_decay = 1'b0;
        feed(0, 0, 100); feed(0, 0, 501); feed(0, 0, 100);
        do_clear();

        tag = "R6 R7 R8 mix";
        for (int k = 0; k < 4000; k++) begin
            smp_abs    = NS*DW'({$urandom, $urandom});
            smp_err    = NS*DW'({$urandom, $urandom});
            smp_vld    = NS'($urandom);
            cfg_src    = SW'($urandom);
            cfg_thresh = DW'(1024 + ($urandom % 64) - 32);
            for (int c = 0; c < NS; c++) begin
                smp_abs[c*DW +: DW] = DW'(1024 + ($urandom % 96) - 48);
                smp_err[c*DW +: DW] = DW'(1024 + ($urandom % 96) - 48);
            end
            cfg_below  = (($urandom % 50) == 0) ? ~cfg_below : cfg_below;
            cfg_decay  = (($urandom % 40) == 0) ? ~cfg_decay : cfg_decay;
            cfg_en     = ($urandom % 20) != 0;
            cfg_irq_en = ($urandom % 8) != 0;
            cfg_limit  = (($urandom % 30) == 0) ? CW'($urandom) : cfg_limit;
            clr        = ($urandom % 25) == 0;
            cyc();
        end
        clr = 1'b0; smp_vld = '0;
        cyc();
        summary();
    end

endmodule